// File: doc/BRIEF.md
# Hardware Cursor Overlay Unit

This block lays a 32x32 two-plane cursor over a stream of display pixels. Software programs the cursor through a 32-bit register port. A position word gives the cursor's top-left corner. Thirty-two transparency words and thirty-two image words hold one cursor row each. A general-purpose control word can be read back.

On the pixel side, the block receives the current raster coordinate and the palette colour of the underlying pixel. Inside the cursor window, a set transparency bit replaces that colour with one of two cursor colours, and the image bit picks which one. Elsewhere the pixel passes through unchanged. The result appears one clock later, aligned with its valid and sync sideband.

Drawing stops at the right edge of the active area and below its last line. After reset the cursor sits far outside any legal raster, which hides it.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, both cursor coordinates are 0xF000, so no pixel is replaced, and a read of the control word at offset 0x818 returns 0x0200_0000.
- R2: A write to offset 0x8FC sets the cursor x from data bits 31:16 and the cursor y from data bits 15:0.
- R3: A write to offset 0x900 + 4*n loads transparency row n, and a write to 0x980 + 4*n loads image row n, for n from 0 to 31.
- R4: In a row word, bit 31 belongs to cursor column 0, the leftmost pixel, and bit 0 belongs to column 31.
- R5: Inside the window, a set transparency bit gives cur_color1 when the image bit is 1 and cur_color0 when it is 0. A clear transparency bit passes pix_color through.
- R6: Cursor rows cover display lines cursor_y through cursor_y+31, and the row used is display y minus cursor_y. Columns cover cursor_x through cursor_x+31.
- R7: Pixels with x at or beyond active_w are never replaced. A cursor whose x is at or beyond active_w draws nothing.
- R8: A read of 0x818 returns the last written control value ORed with bit 25. A read of any other offset returns zero.
- R9: out_valid, out_hsync, out_vsync and out_color follow their inputs with exactly one clock of latency.
- R10: A pixel with pix_valid low, or with y at or beyond active_h, passes through unchanged.
- R11: A write to any offset other than 0x818, 0x8FC and the two row ranges changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| active_w | input | 11 | Active line width in pixels (up to 1024) |
| active_h | input | 10 | Active line count (up to 768) |
| pix_valid | input | 1 | Input pixel valid |
| pix_hsync | input | 1 | Horizontal sync sideband |
| pix_vsync | input | 1 | Vertical sync sideband |
| pix_x | input | 10 | Display x of the input pixel |
| pix_y | input | 10 | Display y of the input pixel |
| pix_color | input | 24 | Palette colour of the underlying pixel |
| cur_color0 | input | 24 | Cursor colour used when the image bit is 0 |
| cur_color1 | input | 24 | Cursor colour used when the image bit is 1 |
| out_valid | output | 1 | Delayed pixel valid |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_color | output | 24 | Merged output colour |

## Verification
Some properties are checked on every cycle:
- the one-cycle alignment of valid, syncs and colour;
- that every output colour is the delayed pixel colour or one of the two delayed cursor colours;
- that invalid pixels and pixels right of or below the active area pass through;
- the forced bit 25 on control reads, and zero on every other read.

Only the directed scenarios can show the rest:
- that a chosen row and column of the programmed shape lands on the right screen pixel;
- the MSB-left bit order;
- right-edge clipping at a given width;
- parking the cursor at 0xF000;
- that stray writes leave the shape and the control word alone.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int unsigned CUR_DIM   = 32;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned CRD_W     = 16;

  localparam logic [31:0] OFS_CTRL  = 32'h0000_0818;
  localparam logic [31:0] OFS_POS   = 32'h0000_08FC;
  localparam logic [31:0] OFS_MASK  = 32'h0000_0900;
  localparam logic [31:0] OFS_IMAGE = 32'h0000_0980;

  localparam logic [31:0] CTRL_FORCE = 32'h0200_0000;
  localparam logic [15:0] PARK_CRD   = 16'hF000;

  typedef enum logic [1:0] {
    SRC_PIXEL = 2'd0,
    SRC_CUR0  = 2'd1,
    SRC_CUR1  = 2'd2
  } color_src_e;

endpackage

// File: rtl/cur_regs.sv
module cur_regs
  import cursor_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIM    = 32,
  parameter int unsigned CW     = 16,
  localparam int unsigned IDX_W = $clog2(DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  row_sel,
  output logic [DIM-1:0]    mask_row,
  output logic [DIM-1:0]    image_row,
  output logic [CW-1:0]     cur_x,
  output logic [CW-1:0]     cur_y
);

  localparam logic [31:0] ROW_SPAN = 32'(DIM * 4);

  logic [31:0]      addr32;
  logic             hit_ctrl, hit_pos, hit_mask, hit_image;
  logic [IDX_W-1:0] widx;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en;
  logic [CW-1:0]     x_q, y_q, x_d, y_d;
  logic              pos_en;

  logic [DIM-1:0] mask_q  [DIM];
  logic [DIM-1:0] image_q [DIM];

  // Address decode
  assign addr32    = 32'(addr);
  assign hit_ctrl  = (addr32 == OFS_CTRL);
  assign hit_pos   = (addr32 == OFS_POS);
  assign hit_mask  = (addr32 >= OFS_MASK)  && (addr32 < OFS_MASK + ROW_SPAN);
  assign hit_image = (addr32 >= OFS_IMAGE) && (addr32 < OFS_IMAGE + ROW_SPAN);
  assign widx      = addr[IDX_W+1:2];

  // Control word
  assign ctrl_en = we && hit_ctrl;
  assign ctrl_d  = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // Position: x in upper half, y in lower half
  assign pos_en = we && hit_pos;
  assign x_d    = wdata[2*CW-1:CW];
  assign y_d    = wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= CW'(PARK_CRD);
      y_q <= CW'(PARK_CRD);
    end else if (pos_en) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  // Row storage, one enable per word
  for (genvar r = 0; r < DIM; r++) begin : g_row
    logic m_en, i_en;
    assign m_en = we && hit_mask  && (widx == IDX_W'(r));
    assign i_en = we && hit_image && (widx == IDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q[r] <= '0;
      else if (m_en) mask_q[r] <= wdata[DIM-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    image_q[r] <= '0;
      else if (i_en) image_q[r] <= wdata[DIM-1:0];
    end
  end

  assign mask_row  = mask_q[row_sel];
  assign image_row = image_q[row_sel];
  assign cur_x     = x_q;
  assign cur_y     = y_q;

  // Read mux: only the control word is visible
  always_comb begin
    rdata = '0;
    if (hit_ctrl) rdata = ctrl_q | DATA_W'(CTRL_FORCE);
  end

endmodule

// File: rtl/cur_hit.sv
module cur_hit #(
  parameter int unsigned X_W = 10,
  parameter int unsigned Y_W = 10,
  parameter int unsigned W_W = 11,
  parameter int unsigned H_W = 10,
  parameter int unsigned CW  = 16,
  parameter int unsigned DIM = 32,
  localparam int unsigned IDX_W = $clog2(DIM),
  localparam int unsigned EXT_W = CW + 1
) (
  input  logic             pix_valid,
  input  logic [X_W-1:0]   pix_x,
  input  logic [Y_W-1:0]   pix_y,
  input  logic [W_W-1:0]   active_w,
  input  logic [H_W-1:0]   active_h,
  input  logic [CW-1:0]    cur_x,
  input  logic [CW-1:0]    cur_y,
  output logic             in_win,
  output logic [IDX_W-1:0] row_idx,
  output logic [IDX_W-1:0] col_idx
);

  logic [EXT_W-1:0] x_e, y_e, cx_e, cy_e, w_e, h_e, dx, dy;
  logic             row_ok, col_ok, vis_ok;

  assign x_e  = EXT_W'(pix_x);
  assign y_e  = EXT_W'(pix_y);
  assign cx_e = EXT_W'(cur_x);
  assign cy_e = EXT_W'(cur_y);
  assign w_e  = EXT_W'(active_w);
  assign h_e  = EXT_W'(active_h);

  assign dx = x_e - cx_e;
  assign dy = y_e - cy_e;

  // Vertical window, horizontal window, then the right and bottom clip
  assign row_ok = (y_e >= cy_e) && (dy < EXT_W'(DIM));
  assign col_ok = (x_e >= cx_e) && (dx < EXT_W'(DIM));
  assign vis_ok = (cx_e < w_e) && (x_e < w_e) && (y_e < h_e);

  assign in_win  = pix_valid && row_ok && col_ok && vis_ok;
  assign row_idx = dy[IDX_W-1:0];
  assign col_idx = dx[IDX_W-1:0];

endmodule

// File: rtl/cur_mix.sv
module cur_mix
  import cursor_pkg::*;
#(
  parameter int unsigned DIM     = 32,
  parameter int unsigned COLOR_W = 24,
  localparam int unsigned IDX_W  = $clog2(DIM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_win,
  input  logic [DIM-1:0]     mask_row,
  input  logic [DIM-1:0]     image_row,
  input  logic [IDX_W-1:0]   col_idx,
  input  logic               pix_valid,
  input  logic               pix_hsync,
  input  logic               pix_vsync,
  input  logic [COLOR_W-1:0] pix_color,
  input  logic [COLOR_W-1:0] cur_color0,
  input  logic [COLOR_W-1:0] cur_color1,
  output logic               out_valid,
  output logic               out_hsync,
  output logic               out_vsync,
  output logic [COLOR_W-1:0] out_color
);

  logic [IDX_W-1:0]   bit_pos;
  logic               m_bit, i_bit;
  color_src_e         src;
  logic [COLOR_W-1:0] color_d, color_q;
  logic               valid_q, hs_q, vs_q;

  // Column 0 sits in the most significant bit
  assign bit_pos = IDX_W'(DIM - 1) - col_idx;
  assign m_bit   = mask_row[bit_pos];
  assign i_bit   = image_row[bit_pos];

  always_comb begin
    src = SRC_PIXEL;
    if (in_win && m_bit) src = i_bit ? SRC_CUR1 : SRC_CUR0;
  end

  always_comb begin
    unique case (src)
      SRC_CUR0: color_d = cur_color0;
      SRC_CUR1: color_d = cur_color1;
      default:  color_d = pix_color;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
      valid_q <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      color_q <= color_d;
      valid_q <= pix_valid;
      hs_q    <= pix_hsync;
      vs_q    <= pix_vsync;
    end
  end

  assign out_color = color_q;
  assign out_valid = valid_q;
  assign out_hsync = hs_q;
  assign out_vsync = vs_q;

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned MAX_W   = 1024,
  parameter int unsigned MAX_H   = 768,
  parameter int unsigned COLOR_W = 24,
  parameter int unsigned ADDR_W  = 12,
  localparam int unsigned X_W    = $clog2(MAX_W),
  localparam int unsigned Y_W    = $clog2(MAX_H),
  localparam int unsigned W_W    = $clog2(MAX_W + 1),
  localparam int unsigned H_W    = $clog2(MAX_H + 1),
  localparam int unsigned IDX_W  = $clog2(CUR_DIM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [W_W-1:0]     active_w,
  input  logic [H_W-1:0]     active_h,
  input  logic               pix_valid,
  input  logic               pix_hsync,
  input  logic               pix_vsync,
  input  logic [X_W-1:0]     pix_x,
  input  logic [Y_W-1:0]     pix_y,
  input  logic [COLOR_W-1:0] pix_color,
  input  logic [COLOR_W-1:0] cur_color0,
  input  logic [COLOR_W-1:0] cur_color1,
  output logic               out_valid,
  output logic               out_hsync,
  output logic               out_vsync,
  output logic [COLOR_W-1:0] out_color
);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [CUR_DIM-1:0] mask_row, image_row;
  logic [CRD_W-1:0]   cur_x, cur_y;
  logic               in_win;
  logic [IDX_W-1:0]   row_idx, col_idx;

  cur_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (REG_W),
    .DIM    (CUR_DIM),
    .CW     (CRD_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .row_sel   (row_idx),
    .mask_row  (mask_row),
    .image_row (image_row),
    .cur_x     (cur_x),
    .cur_y     (cur_y)
  );

  cur_hit #(
    .X_W (X_W),
    .Y_W (Y_W),
    .W_W (W_W),
    .H_W (H_W),
    .CW  (CRD_W),
    .DIM (CUR_DIM)
  ) u_hit (
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .active_w  (active_w),
    .active_h  (active_h),
    .cur_x     (cur_x),
    .cur_y     (cur_y),
    .in_win    (in_win),
    .row_idx   (row_idx),
    .col_idx   (col_idx)
  );

  cur_mix #(
    .DIM     (CUR_DIM),
    .COLOR_W (COLOR_W)
  ) u_mix (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_win     (in_win),
    .mask_row   (mask_row),
    .image_row  (image_row),
    .col_idx    (col_idx),
    .pix_valid  (pix_valid),
    .pix_hsync  (pix_hsync),
    .pix_vsync  (pix_vsync),
    .pix_color  (pix_color),
    .cur_color0 (cur_color0),
    .cur_color1 (cur_color1),
    .out_valid  (out_valid),
    .out_hsync  (out_hsync),
    .out_vsync  (out_vsync),
    .out_color  (out_color)
  );

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int unsigned X_W     = 10,
  parameter int unsigned Y_W     = 10,
  parameter int unsigned W_W     = 11,
  parameter int unsigned H_W     = 10,
  parameter int unsigned COLOR_W = 24,
  parameter int unsigned ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [W_W-1:0]     active_w,
  input logic [H_W-1:0]     active_h,
  input logic               pix_valid,
  input logic               pix_hsync,
  input logic               pix_vsync,
  input logic [X_W-1:0]     pix_x,
  input logic [Y_W-1:0]     pix_y,
  input logic [COLOR_W-1:0] pix_color,
  input logic [COLOR_W-1:0] cur_color0,
  input logic [COLOR_W-1:0] cur_color1,
  input logic               out_valid,
  input logic               out_hsync,
  input logic               out_vsync,
  input logic [COLOR_W-1:0] out_color
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(12'h818);

  a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(pix_valid));

  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_hsync == $past(pix_hsync)) && (out_vsync == $past(pix_vsync)));

  a_r5_color_source: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_color == $past(pix_color)) || (out_color == $past(cur_color0))
             || (out_color == $past(cur_color1)));

  a_r10_invalid_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> out_color == $past(pix_color));

  a_r10_below_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (H_W'(pix_y) >= active_h) |=> out_color == $past(pix_color));

  a_r7_right_clip: assert property (@(posedge clk) disable iff (!rst_n)
    (W_W'(pix_x) >= active_w) |=> out_color == $past(pix_color));

  a_r8_ctrl_force: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == CTRL_A) |-> reg_rdata[25]);

  a_r8_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != CTRL_A) |-> reg_rdata == 32'd0);

endmodule

bind cursor_overlay cursor_overlay_chk #(
  .X_W     (X_W),
  .Y_W     (Y_W),
  .W_W     (W_W),
  .H_W     (H_W),
  .COLOR_W (COLOR_W),
  .ADDR_W  (ADDR_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .active_w   (active_w),
  .active_h   (active_h),
  .pix_valid  (pix_valid),
  .pix_hsync  (pix_hsync),
  .pix_vsync  (pix_vsync),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .pix_color  (pix_color),
  .cur_color0 (cur_color0),
  .cur_color1 (cur_color1),
  .out_valid  (out_valid),
  .out_hsync  (out_hsync),
  .out_vsync  (out_vsync),
  .out_color  (out_color)
);

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;

  logic        clk, rst_n;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [10:0] active_w;
  logic [9:0]  active_h;
  logic        pix_valid, pix_hsync, pix_vsync;
  logic [9:0]  pix_x, pix_y;
  logic [23:0] pix_color, cur_color0, cur_color1;
  logic        out_valid, out_hsync, out_vsync;
  logic [23:0] out_color;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // Reference state kept from the requirements
  logic [31:0] bm [32];
  logic [31:0] bi [32];
  int          mcx, mcy;

  localparam logic [23:0] C0 = 24'hA00000;
  localparam logic [23:0] C1 = 24'hB00000;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active_w(active_w),
    .active_h(active_h), .pix_valid(pix_valid), .pix_hsync(pix_hsync),
    .pix_vsync(pix_vsync), .pix_x(pix_x), .pix_y(pix_y),
    .pix_color(pix_color), .cur_color0(cur_color0), .cur_color1(cur_color1),
    .out_valid(out_valid), .out_hsync(out_hsync), .out_vsync(out_vsync),
    .out_color(out_color)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] base_color(input int x, input int y);
    return {4'h4, 10'(y), 10'(x)};
  endfunction

  function automatic logic [23:0] exp_color(input int x, input int y, input bit v);
    int r, c;
    if (!v) return base_color(x, y);
    if (y >= int'(active_h) || x >= int'(active_w)) return base_color(x, y);
    if (mcx >= int'(active_w)) return base_color(x, y);
    if (y < mcy || y >= mcy + 32 || x < mcx || x >= mcx + 32) return base_color(x, y);
    r = y - mcy;
    c = x - mcx;
    if (!bm[r][31-c]) return base_color(x, y);
    return bi[r][31-c] ? C1 : C0;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 12'h000;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata === exp, req, reg_rdata, exp);
    reg_addr = 12'h000;
  endtask

  task automatic set_pos(input int x, input int y);
    wr(12'h8FC, {16'(x), 16'(y)});
    mcx = x; mcy = y;
  endtask

  task automatic set_row(input int n, input logic [31:0] m, input logic [31:0] im);
    wr(12'(32'h900 + 4 * n), m);
    wr(12'(32'h980 + 4 * n), im);
    bm[n] = m; bi[n] = im;
  endtask

  task automatic pix(input int x, input int y, input bit v, input bit hs,
                     input bit vs, input string req);
    logic [23:0] e;
    @(negedge clk);
    pix_valid = v; pix_hsync = hs; pix_vsync = vs;
    pix_x = 10'(x); pix_y = 10'(y); pix_color = base_color(x, y);
    e = exp_color(x, y, v);
    @(posedge clk);
    #1;
    chk(out_color === e, req, 32'(out_color), 32'(e));
    chk({out_valid, out_hsync, out_vsync} === {v, hs, vs}, "R9", 
        32'({out_valid, out_hsync, out_vsync}), 32'({v, hs, vs}));
    @(negedge clk);
    pix_valid = 1'b0; pix_hsync = 1'b0; pix_vsync = 1'b0;
  endtask

  task automatic scan(input int y, input int x0, input int x1, input string req);
    for (int x = x0; x <= x1; x++) pix(x, y, 1'b1, 1'b0, 1'b0, req);
  endtask

  // R1: reset state
  task automatic t_reset();
    rd_chk(12'h818, 32'h0200_0000, "R1");
    rd_chk(12'h8FC, 32'h0, "R8");
    pix(0, 0, 1'b1, 1'b0, 1'b0, "R1");
    pix(10, 20, 1'b1, 1'b0, 1'b0, "R1");
  endtask

  // R8: control word readback and zero elsewhere
  task automatic t_ctrl();
    wr(12'h818, 32'h0000_00A5);
    rd_chk(12'h818, 32'h0200_00A5, "R8");
    wr(12'h818, 32'hFFFF_FFFF);
    rd_chk(12'h818, 32'hFFFF_FFFF, "R8");
    wr(12'h818, 32'h1000_0001);
    rd_chk(12'h818, 32'h1200_0001, "R8");
    rd_chk(12'h900, 32'h0, "R8");
    rd_chk(12'h980, 32'h0, "R8");
  endtask

  // R2 R3 R4 R5 R6: programmed shape in the middle of the screen
  task automatic t_shape();
    set_pos(100, 50);
    set_row(0,  32'h8000_0001, 32'h8000_0000);
    set_row(5,  32'hF0F0_F0F0, 32'hFF00_FF00);
    set_row(31, 32'hFFFF_FFFF, 32'h5555_5555);
    pix(100, 50, 1'b1, 1'b0, 1'b0, "R4");
    pix(131, 50, 1'b1, 1'b0, 1'b0, "R4");
    pix(101, 50, 1'b1, 1'b0, 1'b0, "R5");
    scan(49, 98, 133, "R6");
    scan(50, 98, 133, "R6");
    scan(55, 98, 133, "R3");
    scan(81, 98, 133, "R6");
    scan(82, 98, 133, "R6");
  endtask

  // R11: stray writes leave shape and control alone
  task automatic t_stray();
    wr(12'h8F8, 32'h0000_0000);
    wr(12'h880, 32'h0000_0000);
    wr(12'hA00, 32'h0000_0000);
    wr(12'h81C, 32'h0000_0000);
    rd_chk(12'h818, 32'h1200_0001, "R11");
    pix(100, 50, 1'b1, 1'b0, 1'b0, "R11");
    pix(104, 55, 1'b1, 1'b0, 1'b0, "R11");
    scan(81, 100, 103, "R11");
  endtask

  // R7: right-edge clipping
  task automatic t_clip();
    active_w = 11'd120;
    scan(81, 116, 131, "R7");
    set_pos(120, 50);
    scan(81, 118, 125, "R7");
    active_w = 11'd1024;
    set_pos(1000, 50);
    scan(81, 996, 1023, "R7");
    set_pos(1023, 50);
    pix(1023, 81, 1'b1, 1'b0, 1'b0, "R7");
  endtask

  // R10: invalid pixels and lines below the active area
  task automatic t_pass();
    set_pos(200, 746);
    pix(200, 777 - 31, 1'b0, 1'b0, 1'b0, "R10");
    pix(200, 777, 1'b1, 1'b0, 1'b0, "R10");
    pix(205, 767, 1'b1, 1'b0, 1'b0, "R10");
    active_h = 10'd760;
    pix(200, 777, 1'b1, 1'b0, 1'b0, "R10");
    pix(205, 767, 1'b1, 1'b0, 1'b0, "R10");
    pix(200, 759, 1'b0, 1'b0, 1'b0, "R10");
    active_h = 10'd768;
  endtask

  // R9: sideband alignment
  task automatic t_side();
    set_pos(300, 300);
    pix(300, 300, 1'b1, 1'b1, 1'b0, "R9");
    pix(300, 331, 1'b0, 1'b0, 1'b1, "R9");
    pix(301, 331, 1'b1, 1'b1, 1'b1, "R9");
    pix(5, 5, 1'b0, 1'b1, 1'b0, "R9");
  endtask

  // R1: parking the cursor hides it
  task automatic t_park();
    set_pos(32'hF000, 32'hF000);
    scan(0, 0, 3, "R1");
    scan(331, 298, 302, "R1");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin bm[i] = '0; bi[i] = '0; end
    mcx = 32'hF000; mcy = 32'hF000;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    active_w = 11'd640; active_h = 10'd480;
    pix_valid = 1'b0; pix_hsync = 1'b0; pix_vsync = 1'b0;
    pix_x = '0; pix_y = '0; pix_color = '0;
    cur_color0 = C0; cur_color1 = C1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    t_reset();
    t_ctrl();
    t_shape();
    t_stray();
    t_clip();
    active_w = 11'd1024; active_h = 10'd768;
    t_pass();
    t_side();
    t_park();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule